// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-up to a usable state. After reset it stays quiet, with every command strobe inactive, until a single-cycle start pulse arrives. It then issues, in a fixed order, the seven commands the device needs before normal traffic: precharge-all, extended mode register load with the DLL enabled, mode register load with DLL reset, a second precharge-all, two auto-refreshes, and a final mode register load. A programmed count of idle cycles follows each command. When the last wait has run out, a done flag goes high and stays high until the next reset.

Each command is a single-clock pulse on otherwise inactive strobes. Internally a command is a set of active-high bits (chip select, write enable, column strobe, row strobe), and these bits are inverted onto the active-low pins. The row/column address and bank address carry the command's operands only in the command cycle. They are zero on every idle cycle. The three wait lengths are parameters. Their defaults are 2 cycles after ordinary commands, 4 after each refresh, and 200 after each mode register load that ends a phase.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held and after reset until the first start pulse, cs_n, ras_n, cas_n and we_n are all 1, addr and bank are 0 and done is 0.
- R2: Internal command bit 0 is chip select, bit 1 write enable, bit 2 column strobe and bit 3 row strobe, all active-high and driven inverted. On the pins as {cs_n,ras_n,cas_n,we_n}, precharge-all is 4'b0010, mode register load is 4'b0000, auto-refresh is 4'b0001 and the idle (NOP) code is 4'b1111.
- R3: Every command lasts exactly one clock. No two consecutive cycles both carry a command, and every other cycle is NOP.
- R4: On a command cycle addr and bank carry that command's operands. On every NOP cycle, after start as well, addr and bank are 0.
- R5: The command order is: precharge-all (addr 0x400, bank 0); extended mode load (addr 0x000, bank 1); mode load (addr 0x132, bank 0); precharge-all (addr 0x400, bank 0); auto-refresh (addr 0, bank 0) twice; mode load (addr 0x032, bank 0). This is exactly seven commands.
- R6: After the DLL-reset mode load and after the final mode load come WAIT_LONG NOP cycles (default 200).
- R7: After each auto-refresh come WAIT_REF NOP cycles (default 4).
- R8: After each of the other commands come WAIT_SHORT NOP cycles (default 2).
- R9: done rises in the cycle right after the last of the WAIT_LONG cycles that follow the final mode load. It stays 1 with no further command until reset.
- R10: A start pulse while the sequence is running, including one sampled on the same edge that issues a command, changes neither the commands nor their timing. A start pulse after done is ignored.
- R11: The first command appears in the cycle right after the edge that samples start in the idle state.
- R12: Reset asserted in the middle of the sequence returns the block to the R1 state. A later start runs the full sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin the power-up sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Row/column address, nonzero only on command cycles |
| bank | output | BANK_W | Bank address, nonzero only on command cycles |
| done | output | 1 | High once the whole sequence has finished |

## Verification
Two events can fall on the same clock edge: the sequencer's own expiry of a wait, which issues the next command, and a stray start request. The bench provokes this by raising start for exactly the cycle before the second precharge-all is due. That edge then both issues that command and samples start. It judges the outcome at the pins: all seven commands must still appear with the same codes and operands, and the gaps between them must match the parameter-derived counts. A pulse during a plain wait and a pulse after done are also exercised.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int CMD_W     = 4;
  localparam int B_CS      = 0;
  localparam int B_WE      = 1;
  localparam int B_CAS     = 2;
  localparam int B_RAS     = 3;
  localparam int NUM_STEPS = 7;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int OPND_W    = 16;

  typedef logic [CMD_W-1:0]  cmd_bits_t;
  typedef logic [STEP_W-1:0] step_idx_t;

  localparam cmd_bits_t CMD_NOP = cmd_bits_t'(0);
  localparam cmd_bits_t CMD_PRE = cmd_bits_t'((1 << B_CS) | (1 << B_RAS) | (1 << B_WE));
  localparam cmd_bits_t CMD_LMR = cmd_bits_t'((1 << B_CS) | (1 << B_RAS) | (1 << B_CAS) | (1 << B_WE));
  localparam cmd_bits_t CMD_REF = cmd_bits_t'((1 << B_CS) | (1 << B_RAS) | (1 << B_CAS));

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} seq_state_t;
  typedef enum logic [1:0] {GAP_SHORT, GAP_REF, GAP_LONG} gap_kind_t;

  // Command issued at each position of the power-up walk
  function automatic cmd_bits_t step_cmd(step_idx_t idx);
    case (idx)
      3'd0, 3'd3:       return CMD_PRE;
      3'd1, 3'd2, 3'd6: return CMD_LMR;
      3'd4, 3'd5:       return CMD_REF;
      default:          return CMD_NOP;
    endcase
  endfunction

  // Address operand (A10 set for precharge-all; mode words for loads)
  function automatic logic [OPND_W-1:0] step_addr(step_idx_t idx);
    case (idx)
      3'd0, 3'd3: return 16'h0400;
      3'd2:       return 16'h0132;
      3'd6:       return 16'h0032;
      default:    return 16'h0000;
    endcase
  endfunction

  // Bank operand: only the extended mode load targets bank 1
  function automatic logic [OPND_W-1:0] step_bank(step_idx_t idx);
    return (idx == 3'd1) ? 16'h0001 : 16'h0000;
  endfunction

  function automatic gap_kind_t step_gap(step_idx_t idx);
    case (idx)
      3'd2, 3'd6: return GAP_LONG;
      3'd4, 3'd5: return GAP_REF;
      default:    return GAP_SHORT;
    endcase
  endfunction

  function automatic int unsigned gap_len(gap_kind_t k, int unsigned w_short,
                                          int unsigned w_ref, int unsigned w_long);
    case (k)
      GAP_LONG: return w_long;
      GAP_REF:  return w_ref;
      default:  return w_short;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter int          BANK_W     = 2,
  parameter int          CNT_W      = 8,
  parameter int unsigned WAIT_SHORT = 2,
  parameter int unsigned WAIT_REF   = 4,
  parameter int unsigned WAIT_LONG  = 200
) (
  input  step_idx_t         idx,
  output cmd_bits_t         cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [CNT_W-1:0]  gap
);

  logic [OPND_W-1:0] addr_full;
  logic [OPND_W-1:0] bank_full;

  always_comb begin
    cmd       = step_cmd(idx);
    addr_full = step_addr(idx);
    bank_full = step_bank(idx);
    gap       = CNT_W'(gap_len(step_gap(idx), WAIT_SHORT, WAIT_REF, WAIT_LONG));
  end

  generate
    if (ADDR_W >= OPND_W) begin : g_addr_wide
      assign addr = {{(ADDR_W-OPND_W){1'b0}}, addr_full};
    end else begin : g_addr_narrow
      assign addr = addr_full[ADDR_W-1:0];
    end
    if (BANK_W >= OPND_W) begin : g_bank_wide
      assign bank = {{(BANK_W-OPND_W){1'b0}}, bank_full};
    end else begin : g_bank_narrow
      assign bank = bank_full[BANK_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/ddr_init_wait_timer.sv
module ddr_init_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && expired) |=> expired); // R8

endmodule

// File: rtl/ddr_init_cmd_drive.sv
module ddr_init_cmd_drive
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  cmd_bits_t         cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BANK_W-1:0] bank_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank
);

  cmd_bits_t         cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;

  // Operands only ride with a command; everything else is a clean NOP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      bank_q <= '0;
    end else if (issue) begin
      cmd_q  <= cmd_in;
      addr_q <= addr_in;
      bank_q <= bank_in;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      bank_q <= '0;
    end
  end

  assign cs_n  = ~cmd_q[B_CS];
  assign ras_n = ~cmd_q[B_RAS];
  assign cas_n = ~cmd_q[B_CAS];
  assign we_n  = ~cmd_q[B_WE];
  assign addr  = addr_q;
  assign bank  = bank_q;

  AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n); // R3
  AST_NOP_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (addr == '0 && bank == '0 && ras_n && cas_n && we_n)); // R4
  AST_CMD_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> cs_n); // R3

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter int          BANK_W     = 2,
  parameter int unsigned WAIT_SHORT = 2,
  parameter int unsigned WAIT_REF   = 4,
  parameter int unsigned WAIT_LONG  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              done
);

  localparam int unsigned MAX_WAIT  = max3(WAIT_SHORT, WAIT_REF, WAIT_LONG);
  localparam int          CNT_W     = $clog2(MAX_WAIT + 1);
  localparam step_idx_t   LAST_STEP = step_idx_t'(NUM_STEPS - 1);

  seq_state_t        state_q;
  step_idx_t         step_q;
  logic              done_q;

  // Named internal events
  logic              tmr_expired;
  logic              wait_over;
  logic              issue_first;
  logic              issue_next;
  logic              issue;
  logic              finish;
  step_idx_t         issue_idx;

  cmd_bits_t         rom_cmd;
  logic [ADDR_W-1:0] rom_addr;
  logic [BANK_W-1:0] rom_bank;
  logic [CNT_W-1:0]  rom_gap;

  assign wait_over   = (state_q == ST_WAIT) && tmr_expired;
  assign issue_first = (state_q == ST_IDLE) && start;
  assign issue_next  = wait_over && (step_q != LAST_STEP);
  assign finish      = wait_over && (step_q == LAST_STEP);
  assign issue       = issue_first || issue_next;
  assign issue_idx   = issue_first ? step_idx_t'(0) : step_idx_t'(step_q + 1'b1);

  ddr_init_step_rom #(
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .CNT_W      (CNT_W),
    .WAIT_SHORT (WAIT_SHORT),
    .WAIT_REF   (WAIT_REF),
    .WAIT_LONG  (WAIT_LONG)
  ) u_rom (
    .idx  (issue_idx),
    .cmd  (rom_cmd),
    .addr (rom_addr),
    .bank (rom_bank),
    .gap  (rom_gap)
  );

  ddr_init_wait_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .load_val (rom_gap),
    .expired  (tmr_expired)
  );

  ddr_init_cmd_drive #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .cmd_in  (rom_cmd),
    .addr_in (rom_addr),
    .bank_in (rom_bank),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr    (addr),
    .bank    (bank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      if (issue) begin
        state_q <= ST_WAIT;
        step_q  <= issue_idx;
      end else if (finish) begin
        state_q <= ST_DONE;
        done_q  <= 1'b1;
      end
    end
  end

  assign done = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (cs_n && ras_n && cas_n && we_n && addr == '0 && bank == '0 && !done)); // R1
  AST_FIRST_CMD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && start) |=> (!cs_n && !ras_n && cas_n && !we_n)); // R11
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && start && !tmr_expired) |=> ($stable(step_q) && cs_n)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9
  AST_DONE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n); // R9

endmodule

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;

  localparam int          ADDR_W = 13;
  localparam int          BANK_W = 2;
  localparam int unsigned WS     = 2;
  localparam int unsigned WR     = 4;
  localparam int unsigned WL     = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, done;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W (ADDR_W), .BANK_W (BANK_W),
    .WAIT_SHORT (WS), .WAIT_REF (WR), .WAIT_LONG (WL)
  ) uut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .addr (addr), .bank (bank), .done (done)
  );

  // Pin monitor, sampled on the falling edge
  int cyc = 0;
  int log_n = 0;
  int dbl_n = 0;
  int nop_bad = 0;
  int done_cyc = -1;
  bit prev_cmd = 1'b0;
  int log_cyc [16];
  logic [3:0] log_code [16];
  int log_addr [16];
  int log_bank [16];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cs_n) begin
        if (prev_cmd) dbl_n++;
        if (log_n < 16) begin
          log_cyc[log_n]  = cyc;
          log_code[log_n] = {cs_n, ras_n, cas_n, we_n};
          log_addr[log_n] = int'(addr);
          log_bank[log_n] = int'(bank);
        end
        log_n++;
      end else if (addr != '0 || bank != '0 || !ras_n || !cas_n || !we_n) begin
        nop_bad++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
    end
    prev_cmd = rst_n && !cs_n;
  end

  // Expected sequence restated from the requirements
  function automatic logic [3:0] exp_code(int i);
    if (i == 0 || i == 3) return 4'b0010;      // precharge-all
    if (i == 4 || i == 5) return 4'b0001;      // auto-refresh
    return 4'b0000;                            // mode loads
  endfunction
  function automatic int exp_addr(int i);
    case (i)
      0, 3: return 'h400;
      2:    return 'h132;
      6:    return 'h032;
      default: return 0;
    endcase
  endfunction
  function automatic int exp_bank(int i);
    return (i == 1) ? 1 : 0;
  endfunction
  function automatic int exp_gap(int i);
    if (i == 2 || i == 6) return int'(WL);
    if (i == 4 || i == 5) return int'(WR);
    return int'(WS);
  endfunction
  function automatic string gap_req(int i);
    if (i == 2 || i == 6) return "R6";
    if (i == 4 || i == 5) return "R7";
    return "R8";
  endfunction
  function automatic int exp_off(int i);
    int o = 0;
    for (int j = 0; j < i; j++) o += exp_gap(j) + 1;
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    log_n = 0; dbl_n = 0; nop_bad = 0; done_cyc = -1;
  endtask

  task automatic check_idle(input string req);
    chk(cs_n && ras_n && cas_n && we_n, req, "strobes idle", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk(addr == '0, req, "addr zero", addr, 0);
    chk(bank == '0, req, "bank zero", bank, 0);
    chk(done == 1'b0, req, "done low", done, 0);
  endtask

  // Test: reset state and quiet idle before any start
  task automatic test_reset_idle();
    rst_n = 1'b0;
    repeat (3) tick();
    check_idle("R1");
    rst_n = 1'b1;
    clear_log();
    repeat (20) tick();
    check_idle("R1");
    chk(log_n == 0, "R1", "no command before start", log_n, 0);
  endtask

  // Test: full sequence; optionally poke start on the issue edge of step 3
  task automatic test_sequence(input bit poke_busy);
    int k;
    int first;
    clear_log();
    k = cyc;
    start = 1'b1;
    tick();
    start = 1'b0;
    first = k + 1;
    if (poke_busy) begin
      // start sampled in a plain wait cycle
      while (cyc < first + 1) tick();
      start = 1'b1; tick(); start = 1'b0;
      // start sampled on the same edge that issues step 3
      while (cyc < first + exp_off(3) - 1) tick();
      start = 1'b1; tick(); start = 1'b0;
    end
    while (cyc < first + exp_off(6) + int'(WL) + 6) tick();

    chk(log_n == 7, "R5", "command count", log_n, 7);
    if (log_n >= 1)
      chk(log_cyc[0] == first, "R11", "first command cycle", log_cyc[0], first);
    for (int i = 0; i < 7 && i < log_n; i++) begin
      chk(log_code[i] == exp_code(i), "R2", $sformatf("code of cmd %0d", i), log_code[i], exp_code(i));
      chk(log_addr[i] == exp_addr(i), "R5", $sformatf("addr of cmd %0d", i), log_addr[i], exp_addr(i));
      chk(log_bank[i] == exp_bank(i), "R4", $sformatf("bank of cmd %0d", i), log_bank[i], exp_bank(i));
      if (i > 0)
        chk(log_cyc[i] - log_cyc[i-1] - 1 == exp_gap(i-1), gap_req(i-1),
            $sformatf("NOP gap after cmd %0d", i-1), log_cyc[i] - log_cyc[i-1] - 1, exp_gap(i-1));
    end
    chk(dbl_n == 0, "R3", "back-to-back command cycles", dbl_n, 0);
    chk(nop_bad == 0, "R4", "NOP cycles with nonzero bus", nop_bad, 0);
    if (log_n >= 7)
      chk(done_cyc == log_cyc[6] + int'(WL) + 1, "R9", "done rise cycle", done_cyc, log_cyc[6] + int'(WL) + 1);
    if (poke_busy && log_n >= 7)
      chk(log_cyc[6] - log_cyc[0] == exp_off(6), "R10", "span with busy start pulses",
          log_cyc[6] - log_cyc[0], exp_off(6));
  endtask

  // Test: done is sticky and start after done is ignored
  task automatic test_after_done();
    clear_log();
    start = 1'b1; tick(); start = 1'b0;
    repeat (30) tick();
    chk(log_n == 0, "R10", "commands after start while done", log_n, 0);
    chk(done == 1'b1, "R9", "done held", done, 1);
    chk(nop_bad == 0, "R9", "bus quiet while done", nop_bad, 0);
  endtask

  // Test: reset in mid-sequence, then a clean rerun
  task automatic test_mid_reset();
    clear_log();
    start = 1'b1; tick(); start = 1'b0;
    repeat (50) tick();
    rst_n = 1'b0;
    tick();
    check_idle("R12");
    rst_n = 1'b1;
    repeat (5) tick();
    check_idle("R12");
    test_sequence(1'b0);
  endtask

  initial begin
    test_reset_idle();
    test_sequence(1'b0);
    test_after_done();
    test_mid_reset();
    rst_n = 1'b0; tick(); rst_n = 1'b1; repeat (3) tick();
    test_sequence(1'b1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule